// File: doc/BRIEF.md
# Two-Phase Toggle Handshake Transfer

This block carries one multi-bit word at a time from a transmit clock domain into a receive clock domain whose clock has no known relation to the first. The transmit side registers the word and flips a one-bit request line. The receive side passes that line through a flip-flop synchronizer and detects the flip. It then loads the word, which has been held steady the whole time, into its own register through a load enable. Finally it flips a one-bit acknowledge line back. The transmit side synchronizes the acknowledge, and once it sees the flip it accepts the next word.

Only the two control bits cross through synchronizers. The data bus is never synchronized. It is sampled only after the control change has been resolved in the receive domain, so by then it has had several receive cycles to settle. A level change in either direction marks one event, so no return-to-zero phase is spent. A transfer costs about three receive cycles plus two to three transmit cycles.

Top module: `hs_toggle_xfer`

## Requirements
- R1: After reset in both domains, `tx_busy` is 0, `rx_strobe` is 0 and `rx_data` is all zeros.
- R2: When `tx_valid` is 1 and `tx_busy` is 0 at a rising `tx_clk` edge, the word on `tx_data` is accepted and `tx_busy` reads 1 after that edge.
- R3: Each accepted word produces exactly one `rx_strobe` pulse, and that pulse is exactly one `rx_clk` cycle wide.
- R4: `rx_data` holds the accepted word while `rx_strobe` is 1, and words arrive in the order they were accepted. Sending 0x0f and then 0x02 yields two strobes carrying 0x0f and then 0x02.
- R5: Changes on `tx_data` after a word has been accepted have no effect on the word that is delivered.
- R6: A `tx_valid` pulse while `tx_busy` is 1 is ignored: it produces no strobe and no later delivery.
- R7: `tx_busy` returns to 0 within 16 `tx_clk` cycles of acceptance, with the default two-stage synchronizers and the receive clock no slower than 1.5 times the transmit period. The strobe for that word has already been seen by then.
- R8: A request change from 1 to 0 counts as a transfer just as a change from 0 to 1 does, so consecutive words, and words sent back to back, are each delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Transmit domain clock |
| tx_rst | input | 1 | Transmit domain reset, synchronous, active high |
| tx_valid | input | 1 | Offer `tx_data` for transfer |
| tx_data | input | DATA_W | Word offered for transfer |
| tx_busy | output | 1 | A transfer is in flight; new offers are ignored |
| rx_clk | input | 1 | Receive domain clock |
| rx_rst | input | 1 | Receive domain reset, synchronous, active high |
| rx_strobe | output | 1 | One-cycle pulse: `rx_data` holds a new word |
| rx_data | output | DATA_W | Last received word |

## Verification
If the request or acknowledge toggle gets out of step between the two sides, the fault shows within one transfer. Either `tx_busy` stays high past its bound, or an extra or missing `rx_strobe` puts the count of delivered words out of line with the count of accepted ones. If the held word is corrupted, or the receive register loads at the wrong time, the fault appears on `rx_data` at the very next strobe, as a value that differs from what was accepted. The bench scrambles `tx_data` right after each acceptance and offers words while busy, so loading from the live bus or accepting while busy both show up as wrong data or extra strobes.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // Default number of flip-flops in each control-bit synchronizer.
  localparam int unsigned HS_SYNC_DEPTH = 2;
  // Default width of the transferred word.
  localparam int unsigned HS_DATA_W = 8;
endpackage

// File: rtl/hs_bit_sync.sv
module hs_bit_sync #(
  parameter int unsigned STAGES = hs_pkg::HS_SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar gi;
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

  initial begin
    a_depth_min: assert (STAGES >= 2);
  end
endmodule

// File: rtl/hs_tx_side.sv
module hs_tx_side #(
  parameter int unsigned DATA_W = hs_pkg::HS_DATA_W,
  parameter int unsigned STAGES = hs_pkg::HS_SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  input  logic              ack_async,
  output logic              req_tog,
  output logic [DATA_W-1:0] hold_q,
  output logic              busy
);
  logic ack_sync;
  logic ack_seen;
  logic ack_evt;
  logic take;

  hs_bit_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .d_async(ack_async), .q(ack_sync)
  );

  assign ack_evt = ack_sync ^ ack_seen;
  assign take    = valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_tog  <= 1'b0;
      hold_q   <= '0;
      busy     <= 1'b0;
      ack_seen <= 1'b0;
    end else begin
      ack_seen <= ack_sync;
      if (ack_evt) busy <= 1'b0;
      if (take) begin
        hold_q  <= data;
        req_tog <= ~req_tog;
        busy    <= 1'b1;
      end
    end
  end

  // R5: the held word does not move while a transfer is in flight
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(hold_q));
  // R6: an offer made while busy must not raise a new request
  a_r6_no_req_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(req_tog));
  // R2: acceptance sets busy
  a_r2_busy_on_take: assert property (@(posedge clk) disable iff (rst)
    take |=> busy);
endmodule

// File: rtl/hs_rx_side.sv
module hs_rx_side #(
  parameter int unsigned DATA_W = hs_pkg::HS_DATA_W,
  parameter int unsigned STAGES = hs_pkg::HS_SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_async,
  input  logic [DATA_W-1:0] data_held,
  output logic              strobe,
  output logic [DATA_W-1:0] data_q,
  output logic              ack_tog
);
  logic req_sync;
  logic req_seen;
  logic req_evt;

  hs_bit_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .d_async(req_async), .q(req_sync)
  );

  assign req_evt = req_sync ^ req_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_seen <= 1'b0;
      strobe   <= 1'b0;
      data_q   <= '0;
      ack_tog  <= 1'b0;
    end else begin
      req_seen <= req_sync;
      strobe   <= req_evt;
      if (req_evt) begin
        data_q  <= data_held;
        ack_tog <= ~ack_tog;
      end
    end
  end

  // R3: a strobe lasts exactly one receive cycle
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
  // R8: every delivery is answered by one acknowledge change
  a_r8_ack_with_strobe: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (ack_tog != $past(ack_tog)));
  // R4: the delivered word stays put between strobes
  a_r4_data_held: assert property (@(posedge clk) disable iff (rst)
    !strobe |-> $stable(data_q));
endmodule

// File: rtl/hs_toggle_xfer.sv
module hs_toggle_xfer #(
  parameter int unsigned DATA_W = hs_pkg::HS_DATA_W,
  parameter int unsigned STAGES = hs_pkg::HS_SYNC_DEPTH
) (
  input  logic              tx_clk,
  input  logic              tx_rst,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_busy,
  input  logic              rx_clk,
  input  logic              rx_rst,
  output logic              rx_strobe,
  output logic [DATA_W-1:0] rx_data
);
  logic              req_line;
  logic              ack_line;
  logic [DATA_W-1:0] held_word;

  hs_tx_side #(.DATA_W(DATA_W), .STAGES(STAGES)) u_tx (
    .clk(tx_clk), .rst(tx_rst), .valid(tx_valid), .data(tx_data),
    .ack_async(ack_line), .req_tog(req_line), .hold_q(held_word),
    .busy(tx_busy)
  );

  hs_rx_side #(.DATA_W(DATA_W), .STAGES(STAGES)) u_rx (
    .clk(rx_clk), .rst(rx_rst), .req_async(req_line),
    .data_held(held_word), .strobe(rx_strobe), .data_q(rx_data),
    .ack_tog(ack_line)
  );
endmodule

// File: tb/test_hs_toggle_xfer.sv
module test_hs_toggle_xfer;
  localparam int W = 8;

  logic         tx_clk = 1'b0;
  logic         rx_clk = 1'b0;
  logic         tx_rst = 1'b1;
  logic         rx_rst = 1'b1;
  logic         tx_valid = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         tx_busy;
  logic         rx_strobe;
  logic [W-1:0] rx_data;

  always #2 tx_clk = ~tx_clk;   // 250 MHz
  always #3 rx_clk = ~rx_clk;   // unrelated receive clock

  hs_toggle_xfer #(.DATA_W(W)) i_hs_toggle_xfer (
    .tx_clk(tx_clk), .tx_rst(tx_rst), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_busy(tx_busy), .rx_clk(rx_clk), .rx_rst(rx_rst),
    .rx_strobe(rx_strobe), .rx_data(rx_data)
  );

  int           n_checks = 0;
  int           n_fail   = 0;
  int           sent     = 0;
  int           got      = 0;
  logic [W-1:0] exp_mem [0:255];
  bit           prev_strobe = 1'b0;
  bit           done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Receive monitor: R3 width, R4 value and order
  always @(negedge rx_clk) begin
    if (!rx_rst) begin
      if (rx_strobe) begin
        check(!prev_strobe, "R3 strobe wider than one cycle", 1, 0);
        check(got < sent && rx_data == exp_mem[got[7:0]], "R4 delivered word",
              int'(rx_data), int'(exp_mem[got[7:0]]));
        got++;
      end
      prev_strobe = rx_strobe;
    end
  end

  // Offer one word; optionally poke while busy (R6); wait for completion (R7)
  task automatic send(input logic [W-1:0] v, input bit poke, input int gap);
    for (int i = 0; i < gap; i++) @(negedge tx_clk);
    @(negedge tx_clk);
    while (tx_busy) @(negedge tx_clk);
    tx_valid = 1'b1;
    tx_data  = v;
    exp_mem[sent[7:0]] = v;
    sent++;
    @(negedge tx_clk);
    tx_valid = 1'b0;
    check(tx_busy, "R2 busy after accept", int'(tx_busy), 1);
    tx_data = W'($urandom);           // R5: scramble the live bus
    if (poke) begin
      tx_valid = 1'b1;                 // R6: offer while busy
      tx_data  = ~v;
      @(negedge tx_clk);
      tx_valid = 1'b0;
      tx_data  = W'($urandom);
    end
    begin
      int cnt = 0;
      while (tx_busy && cnt < 16) begin
        @(negedge tx_clk);
        cnt++;
      end
      check(!tx_busy, "R7 busy clears in bound", cnt, 16);
    end
    check(got == sent, "R3 R6 one strobe per accepted word", got, sent);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", got, sent);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge rx_clk);
    rx_rst = 1'b0;
    @(negedge tx_clk);
    tx_rst = 1'b0;
    @(negedge tx_clk);
    // R1 reset state
    check(tx_busy == 1'b0, "R1 busy after reset", int'(tx_busy), 0);
    check(rx_strobe == 1'b0, "R1 strobe after reset", int'(rx_strobe), 0);
    check(rx_data == '0, "R1 data after reset", int'(rx_data), 0);

    // R4 / R8 directed pair: 0->1 then 1->0 request change
    send(8'h0f, 1'b0, 0);
    send(8'h02, 1'b0, 0);
    check(got == 2, "R8 both toggle directions delivered", got, 2);
    check(rx_data == 8'h02, "R4 last word held", int'(rx_data), 2);

    // corner words and busy pokes
    send(8'h00, 1'b1, 0);
    send(8'hff, 1'b1, 3);
    send(8'h5a, 1'b0, 0);

    // random mix
    for (int k = 0; k < 40; k++)
      send(W'($urandom), 1'($urandom), int'($urandom_range(0, 4)));

    repeat (20) @(negedge rx_clk);
    check(got == sent, "R3 R6 final delivery count", got, sent);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule